// File: doc/BRIEF.md
# Serial EEPROM Write Protection and Status Unit

This unit holds the status register of a serial non-volatile memory and rules on whether each write may go ahead. It keeps a write-enable flag, a two-bit protected-region selector and a lock-enable bit that lets an external protect pin freeze the status register. It also times the internal programming cycle with a counter and raises a busy flag for the whole of it. The serial front end sends it decoded command pulses: set or clear the write-enable flag, stage a status byte, stage an array write for the address on `chk_addr`, and `commit` when chip select rises.

Every pin is a plain control or status level or a single-cycle pulse. No byte stream passes through the unit, so it has no valid/ready handshake and applies no back-pressure. A pulse that arrives while a cycle runs is dropped; the front end needs no retry logic. The non-volatile bits are modelled as ordinary flops. The cycle length is the parameter `CYC_CLKS`, counted in system clocks.

Top module: `wps_top`

## Requirements
- R1: After reset, `status_byte` is 8'h00, `busy` is 0, and both permission outputs are 0.
- R2: A `wren_req` pulse sets status bit 1 (write enable) on the next cycle. A `wrdi_req` pulse clears it whatever the level of `wp_pin`. `wrdi_req` wins if both arrive together.
- R3: When idle, `status_byte` is {lock-enable, 3'b000, region[1], region[0], write-enable, 0}, with lock-enable in bit 7.
- R4: A commit that starts a write cycle holds `busy` high and `status_byte` at 8'hFF for exactly `CYC_CLKS` cycles.
- R5: When a write cycle ends, the write-enable flag clears and `busy` drops on the same edge.
- R6: Region bits 2'b00 protect no address. 2'b01 protects addresses whose two top bits are 11. 2'b10 protects addresses whose top bit is 1. 2'b11 protects every address. `addr_wr_ok` is 0 for a protected `chk_addr`.
- R7: With `wp_pin` low and the lock-enable bit set, `sr_wr_ok` is 0 and a staged status byte changes nothing, including the lock-enable bit.
- R8: With `wp_pin` high, or the lock-enable bit clear, the status register accepts writes when write-enable is set. Unprotected array addresses accept writes with write-enable set at any pin level.
- R9: If the lock takes effect between staging a status byte and the commit, the status write is dropped and no cycle starts. A pin change after the commit has no effect on that write.
- R10: A committed status write updates only bits 7, 3 and 2 from the staged byte.
- R11: While `busy` is high, `wren_req`, `wrdi_req`, `sr_stage`, `arr_stage` and `commit` have no effect, and both permission outputs read 0.
- R12: An array stage is accepted only when write-enable is set and `chk_addr` is unprotected. A commit with nothing accepted starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_pin | input | 1 | Protect pin level; low requests the hardware lock |
| wren_req | input | 1 | Pulse: set the write-enable flag |
| wrdi_req | input | 1 | Pulse: clear the write-enable flag |
| sr_stage | input | 1 | Pulse: status data byte received |
| sr_data | input | 8 | Staged status byte |
| arr_stage | input | 1 | Pulse: array data byte received for `chk_addr` |
| chk_addr | input | ADDR_W | Array address being checked |
| commit | input | 1 | Pulse: chip select released; start any pending write |
| status_byte | output | 8 | Readable status byte |
| addr_wr_ok | output | 1 | `chk_addr` may be written now |
| sr_wr_ok | output | 1 | Status register may be written now |
| busy | output | 1 | Internal write cycle in progress |

## Verification
The hardest case to reach is the abort race. A status byte has to be accepted while writing is still allowed. The lock then has to engage and the pin has to return high before the commit, so that the status register looks writable again at the moment of commit. The bench first commits a lock-enable bit. It stages a byte with the pin high, pulses the pin low and back, and then commits. It then checks that `busy` stays low and the status byte is unchanged. A second sequence drops the pin during a running cycle to show that a write already started still completes.

// File: rtl/wps_pkg.sv
package wps_pkg;
  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_lvl_e;

  localparam int SR_LOCK_BIT = 7;
  localparam int SR_RGN_HI   = 3;
  localparam int SR_RGN_LO   = 2;
  localparam int SR_WEN_BIT  = 1;
  localparam int SR_RDY_BIT  = 0;
endpackage

// File: rtl/wps_region.sv
module wps_region #(
  parameter int ADDR_W = 15
) (
  input  wps_pkg::prot_lvl_e  lvl,
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit
);
  localparam int TOP = ADDR_W - 1;

  always_comb begin
    unique case (lvl)
      wps_pkg::PROT_NONE: hit = 1'b0;
      wps_pkg::PROT_QTR:  hit = addr[TOP] & addr[TOP-1];
      wps_pkg::PROT_HALF: hit = addr[TOP];
      default:            hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/wps_cycle_timer.sv
module wps_cycle_timer #(
  parameter int CYC_CLKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYC_CLKS + 1);

  logic [CW-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (busy)           cnt <= cnt - CW'(1);
    else if (start)          cnt <= CW'(CYC_CLKS);
  end
endmodule

// File: rtl/wps_status_regs.sv
module wps_status_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       done,
  input  logic       lock,
  input  logic       addr_hit,
  input  logic       wren_req,
  input  logic       wrdi_req,
  input  logic       sr_stage,
  input  logic [7:0] sr_data,
  input  logic       arr_stage,
  input  logic       commit,
  output logic       wen,
  output logic       lock_en,
  output logic [1:0] rgn,
  output logic       start
);
  logic       sr_pend;
  logic [7:0] sr_buf;
  logic       arr_pend;
  logic       idle_commit;
  logic       sr_fire;

  assign idle_commit = !busy && commit;
  assign sr_fire     = idle_commit && sr_pend && !lock;
  assign start       = sr_fire || (idle_commit && arr_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         wen <= 1'b0;
    else if (done)                      wen <= 1'b0;
    else if (!busy && wrdi_req)         wen <= 1'b0;
    else if (!busy && wren_req)         wen <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_pend <= 1'b0;
      sr_buf  <= '0;
    end else if (lock || idle_commit) begin
      sr_pend <= 1'b0;
    end else if (!busy && sr_stage && wen) begin
      sr_pend <= 1'b1;
      sr_buf  <= sr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  arr_pend <= 1'b0;
    else if (idle_commit)                        arr_pend <= 1'b0;
    else if (!busy && arr_stage && wen && !addr_hit) arr_pend <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_en <= 1'b0;
      rgn     <= '0;
    end else if (sr_fire) begin
      lock_en <= sr_buf[wps_pkg::SR_LOCK_BIT];
      rgn     <= sr_buf[wps_pkg::SR_RGN_HI:wps_pkg::SR_RGN_LO];
    end
  end
endmodule

// File: rtl/wps_top.sv
module wps_top #(
  parameter int ADDR_W   = 15,
  parameter int CYC_CLKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              wren_req,
  input  logic              wrdi_req,
  input  logic              sr_stage,
  input  logic [7:0]        sr_data,
  input  logic              arr_stage,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              commit,
  output logic [7:0]        status_byte,
  output logic              addr_wr_ok,
  output logic              sr_wr_ok,
  output logic              busy
);
  logic       cyc_busy, cyc_done, cyc_start;
  logic       wen, lock_en, lock, hit;
  logic [1:0] rgn;

  assign lock = !wp_pin && lock_en;

  wps_region #(.ADDR_W(ADDR_W)) u_region (
    .lvl  (wps_pkg::prot_lvl_e'(rgn)),
    .addr (chk_addr),
    .hit  (hit)
  );

  wps_cycle_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cyc_start),
    .busy  (cyc_busy),
    .done  (cyc_done)
  );

  wps_status_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (cyc_busy),
    .done      (cyc_done),
    .lock      (lock),
    .addr_hit  (hit),
    .wren_req  (wren_req),
    .wrdi_req  (wrdi_req),
    .sr_stage  (sr_stage),
    .sr_data   (sr_data),
    .arr_stage (arr_stage),
    .commit    (commit),
    .wen       (wen),
    .lock_en   (lock_en),
    .rgn       (rgn),
    .start     (cyc_start)
  );

  always_comb begin
    if (cyc_busy) status_byte = 8'hFF;
    else          status_byte = {lock_en, 3'b000, rgn, wen, 1'b0};
  end

  assign busy       = cyc_busy;
  assign addr_wr_ok = wen && !cyc_busy && !hit;
  assign sr_wr_ok   = wen && !cyc_busy && !lock;
endmodule

// File: rtl/wps_top_chk.sv
module wps_top_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_pin,
  input logic       wren_req,
  input logic       wrdi_req,
  input logic [7:0] status_byte,
  input logic       addr_wr_ok,
  input logic       sr_wr_ok,
  input logic       busy
);
  a_r4_busy_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_byte == 8'hFF);

  a_r3_unused_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> status_byte[6:4] == 3'b000 && !status_byte[0]);

  a_r5_wen_cleared_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !status_byte[1]);

  a_r7_lock_blocks_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !wp_pin && status_byte[7]) |-> !sr_wr_ok);

  a_r11_no_grant_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sr_wr_ok && !addr_wr_ok);

  a_r6_all_protected: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && status_byte[3:2] == 2'b11) |-> !addr_wr_ok);

  a_r2_wren_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (wren_req && !wrdi_req && !busy) |=> status_byte[1]);
endmodule

bind wps_top wps_top_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wp_pin      (wp_pin),
  .wren_req    (wren_req),
  .wrdi_req    (wrdi_req),
  .status_byte (status_byte),
  .addr_wr_ok  (addr_wr_ok),
  .sr_wr_ok    (sr_wr_ok),
  .busy        (busy)
);

// File: tb/sim_wps_top.sv
module sim_wps_top;
  localparam int AW  = 15;
  localparam int CYC = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp_pin = 1'b1;
  logic          wren_req = 1'b0, wrdi_req = 1'b0;
  logic          sr_stage = 1'b0, arr_stage = 1'b0, commit = 1'b0;
  logic [7:0]    sr_data = '0;
  logic [AW-1:0] chk_addr = '0;
  logic [7:0]    status_byte;
  logic          addr_wr_ok, sr_wr_ok, busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wps_top #(.ADDR_W(AW), .CYC_CLKS(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
    .wren_req(wren_req), .wrdi_req(wrdi_req),
    .sr_stage(sr_stage), .sr_data(sr_data),
    .arr_stage(arr_stage), .chk_addr(chk_addr), .commit(commit),
    .status_byte(status_byte), .addr_wr_ok(addr_wr_ok),
    .sr_wr_ok(sr_wr_ok), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_wren();
    wren_req = 1'b1; @(negedge clk); wren_req = 1'b0;
  endtask
  task automatic pulse_wrdi();
    wrdi_req = 1'b1; @(negedge clk); wrdi_req = 1'b0;
  endtask
  task automatic pulse_commit();
    commit = 1'b1; @(negedge clk); commit = 1'b0;
  endtask
  task automatic stage_sr(input logic [7:0] d);
    sr_data = d; sr_stage = 1'b1; @(negedge clk); sr_stage = 1'b0;
  endtask
  task automatic stage_arr(input logic [AW-1:0] a);
    chk_addr = a; arr_stage = 1'b1; @(negedge clk); arr_stage = 1'b0;
  endtask
  task automatic wait_idle();
    for (int i = 0; i < CYC + 4 && busy; i++) @(negedge clk);
  endtask
  task automatic set_status(input logic [7:0] d);
    pulse_wren(); stage_sr(d); pulse_commit(); wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 status", status_byte, 8'h00);
    chk("R1 busy", busy, 0);
    chk("R1 sr_wr_ok", sr_wr_ok, 0);
    chk("R1 addr_wr_ok", addr_wr_ok, 0);
  endtask

  task automatic t_enable_flag();
    pulse_wren();
    chk("R2 wren sets bit1 / R3 layout", status_byte, 8'h02);
    chk("R8 sr_wr_ok with wen", sr_wr_ok, 1);
    wp_pin = 1'b0;
    @(negedge clk);
    pulse_wrdi();
    chk("R2 wrdi clears with pin low", status_byte, 8'h00);
    wp_pin = 1'b1;
    wrdi_req = 1'b1; wren_req = 1'b1; @(negedge clk);
    wrdi_req = 1'b0; wren_req = 1'b0;
    chk("R2 wrdi wins over wren", status_byte, 8'h00);
  endtask

  task automatic t_cycle_and_mask();
    pulse_wren(); stage_sr(8'hFF); pulse_commit();
    chk("R4 busy after commit", busy, 1);
    chk("R4 status reads FF", status_byte, 8'hFF);
    repeat (CYC - 1) @(negedge clk);
    chk("R4 busy at last cycle", busy, 1);
    @(negedge clk);
    chk("R4 busy ends after CYC", busy, 0);
    chk("R10 only bits 7,3,2 / R5 wen clear", status_byte, 8'h8C);
  endtask

  task automatic t_regions();
    pulse_wren();
    chk_addr = 15'h0000; #1;
    chk("R6 lvl3 addr 0 protected", addr_wr_ok, 0);
    wait_idle();
    set_status(8'h04);
    pulse_wren();
    chk_addr = 15'h5FFF; #1; chk("R6 lvl1 5FFF open", addr_wr_ok, 1);
    chk_addr = 15'h6000; #1; chk("R6 lvl1 6000 protected", addr_wr_ok, 0);
    stage_arr(15'h7000); pulse_commit();
    chk("R12 protected stage starts nothing", busy, 0);
    stage_arr(15'h1000); pulse_commit();
    chk("R12 open stage starts cycle", busy, 1);
    wait_idle();
    chk("R5 wen cleared after array cycle", status_byte, 8'h04);
    stage_arr(15'h1000); pulse_commit();
    chk("R12 no wen no cycle", busy, 0);
    set_status(8'h08);
    pulse_wren();
    chk_addr = 15'h3FFF; #1; chk("R6 lvl2 3FFF open", addr_wr_ok, 1);
    chk_addr = 15'h4000; #1; chk("R6 lvl2 4000 protected", addr_wr_ok, 0);
    pulse_wrdi();
    set_status(8'h00);
    pulse_wren();
    chk_addr = 15'h7FFF; #1; chk("R6 lvl0 7FFF open", addr_wr_ok, 1);
    pulse_wrdi();
  endtask

  task automatic t_lock();
    set_status(8'h80);
    chk("R3 lock-enable bit", status_byte, 8'h80);
    wp_pin = 1'b0;
    pulse_wren();
    chk("R7 sr_wr_ok blocked", sr_wr_ok, 0);
    stage_sr(8'h00); pulse_commit();
    chk("R7 locked commit no cycle", busy, 0);
    chk("R7 status unchanged", status_byte, 8'h82);
    chk_addr = 15'h2000; #1;
    chk("R8 array open with pin low", addr_wr_ok, 1);
    wp_pin = 1'b1;
    @(negedge clk);
    stage_sr(8'h00);
    wp_pin = 1'b0; @(negedge clk); wp_pin = 1'b1; @(negedge clk);
    pulse_commit();
    chk("R9 abort no cycle", busy, 0);
    chk("R9 abort status kept", status_byte, 8'h82);
    stage_sr(8'h0C); pulse_commit();
    wp_pin = 1'b0;
    wait_idle();
    chk("R9 pin after commit no effect", status_byte, 8'h0C);
    set_status(8'h08);
    chk("R8 writable pin low lock off", status_byte, 8'h08);
    wp_pin = 1'b1;
  endtask

  task automatic t_busy_ignore();
    set_status(8'h00);
    pulse_wren(); stage_arr(15'h0010); pulse_commit();
    chk("R11 cycle running", busy, 1);
    chk("R11 sr_wr_ok low while busy", sr_wr_ok, 0);
    pulse_wren(); stage_sr(8'h8C); pulse_commit();
    wait_idle();
    chk("R11 requests ignored", status_byte, 8'h00);
    @(negedge clk);
    chk("R11 no second cycle", busy, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable_flag();
    t_cycle_and_mask();
    t_regions();
    t_lock();
    t_busy_ignore();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule